// File: doc/BRIEF.md
# Delayed-Branch Next-PC Sequencer

This block owns the program counter of a 32-bit core with fixed 4-byte instructions and an architectural branch delay slot. On every cycle where an instruction is issued, it takes that instruction's decoded control-transfer kind, the two source register values, a 16-bit displacement and a 26-bit absolute jump field. It resolves the condition and forms the destination address. It then advances the PC so that the instruction that follows a taken branch or jump is always issued before the PC moves to the destination.

A taken transfer is held in a one-entry pending target register. The redirect lands on the cycle after the delay-slot instruction issues. Call-type instructions produce a write of the return address, which skips the delay slot, to the link register. They produce it in the same cycle they issue, and this happens whether or not a conditional call is taken. Fetch, decode and the register file sit around the block and are not part of it.

Top module: `pc_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `pc_o` equals the parameter `RESET_PC`, `slot_o` is 0 and `link_we_o` is 0.
- R2: On a cycle with `issue_i` low, the PC, the slot flag and any pending redirect are kept unchanged, and `link_we_o` is 0.
- R3: An issued instruction that is not in a delay slot advances the PC by 4. Codes 0 (no transfer) and 12 to 15 never transfer control.
- R4: Code 1 is taken when `rs_val_i` equals `rt_val_i`. Code 2 is taken when they differ.
- R5: The zero-compare codes test `rs_val_i` as a signed value. Code 3 is taken when it is <= 0, code 4 when > 0, codes 5 and 7 when < 0, and codes 6 and 8 when >= 0.
- R6: A taken conditional branch targets (branch PC + 4) + (sign-extended `off_i` shifted left by 2).
- R7: After a taken transfer issues at PC P, the next PC is P+4 and `slot_o` is 1. When that slot instruction issues, the PC becomes the target and `slot_o` returns to 0.
- R8: Codes 9 and 10 are always taken. Their target keeps bits [31:28] of (PC + 4) and places `jt_i` shifted left by 2 below them.
- R9: Code 11 is always taken. It targets `rs_val_i` with its two low bits forced to 0, so the PC stays a multiple of 4.
- R10: Codes 7, 8 and 10 assert `link_we_o` in their issue cycle, whether or not they are taken. In that cycle `link_idx_o` is `LINK_REG` (31) and `link_val_o` is the instruction's PC + 8.
- R11: A control-transfer instruction issued in a delay slot neither redirects nor writes the link register. The PC goes to the pending target only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction at `pc_o` issues this cycle |
| op_i | input | 4 | Decoded control-transfer code |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| off_i | input | 16 | Branch displacement in instructions |
| jt_i | input | 26 | Absolute jump field |
| pc_o | output | 32 | Address of the instruction to issue |
| slot_o | output | 1 | Instruction at `pc_o` sits in a delay slot |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index |
| link_val_o | output | 32 | Return address to write |

## Verification
The bench builds the block with its default field widths and a reset vector of 0xA000_0000. With that vector the upper address bits that absolute jumps must keep are nonzero, so a wrong region splice is visible. Source values come from a pool that includes zero, ±1 and both signed extremes, with repeated equal pairs. This puts every signed-compare boundary within reach. Random issue gaps and random codes in delay slots cover stalls that fall between a branch and its slot, as well as transfers placed inside slots.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_BEQ    = 4'd1,
        OP_BNE    = 4'd2,
        OP_BLEZ   = 4'd3,
        OP_BGTZ   = 4'd4,
        OP_BLTZ   = 4'd5,
        OP_BGEZ   = 4'd6,
        OP_BLTZL  = 4'd7,
        OP_BGEZL  = 4'd8,
        OP_JMP    = 4'd9,
        OP_JMPL   = 4'd10,
        OP_JREG   = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        TK_BRANCH = 2'd0,
        TK_ABS    = 2'd1,
        TK_REG    = 2'd2
    } tgt_kind_e;

endpackage

// File: rtl/pcs_cond.sv
module pcs_cond
    import pc_seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] rs_i,
    input  logic [DW-1:0] rt_i,
    output logic          take_o,
    output logic          link_o,
    output tgt_kind_e     kind_o
);
    logic neg;
    logic zero;
    logic eq;
    op_e  op;

    assign op   = op_e'(op_i);
    assign neg  = rs_i[DW-1];
    assign zero = (rs_i == '0);
    assign eq   = (rs_i == rt_i);

    always_comb begin
        take_o = 1'b0;
        link_o = 1'b0;
        kind_o = TK_BRANCH;
        unique case (op)
            OP_BEQ:   take_o = eq;
            OP_BNE:   take_o = !eq;
            OP_BLEZ:  take_o = neg || zero;
            OP_BGTZ:  take_o = !neg && !zero;
            OP_BLTZ:  take_o = neg;
            OP_BGEZ:  take_o = !neg;
            OP_BLTZL: begin
                take_o = neg;
                link_o = 1'b1;
            end
            OP_BGEZL: begin
                take_o = !neg;
                link_o = 1'b1;
            end
            OP_JMP: begin
                take_o = 1'b1;
                kind_o = TK_ABS;
            end
            OP_JMPL: begin
                take_o = 1'b1;
                link_o = 1'b1;
                kind_o = TK_ABS;
            end
            OP_JREG: begin
                take_o = 1'b1;
                kind_o = TK_REG;
            end
            default: take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcs_target.sv
module pcs_target
    import pc_seq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 16,
    parameter int JTW  = 26
) (
    input  tgt_kind_e       kind_i,
    input  logic [AW-1:0]   pc_i,
    input  logic [AW-1:0]   rs_i,
    input  logic [OFFW-1:0] off_i,
    input  logic [JTW-1:0]  jt_i,
    output logic [AW-1:0]   tgt_o,
    output logic [AW-1:0]   link_o
);
    localparam int EXTW    = AW - OFFW - 2;
    localparam int REGIONW = AW - JTW - 2;

    logic [AW-1:0] slot_pc;
    logic [AW-1:0] disp;
    logic [AW-1:0] br_tgt;
    logic [AW-1:0] abs_tgt;
    logic [AW-1:0] reg_tgt;

    assign slot_pc = pc_i + AW'(4);
    assign link_o  = pc_i + AW'(8);
    assign disp    = {{EXTW{off_i[OFFW-1]}}, off_i, 2'b00};
    assign br_tgt  = slot_pc + disp;
    assign abs_tgt = {slot_pc[AW-1 -: REGIONW], jt_i, 2'b00};
    assign reg_tgt = {rs_i[AW-1:2], 2'b00};

    always_comb begin
        unique case (kind_i)
            TK_ABS:  tgt_o = abs_tgt;
            TK_REG:  tgt_o = reg_tgt;
            default: tgt_o = br_tgt;
        endcase
    end
endmodule

// File: rtl/pc_seq.sv
module pc_seq
    import pc_seq_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          OFFW     = 16,
    parameter int          JTW      = 26,
    parameter int          RW       = 5,
    parameter int          LINK_REG = 31,
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic            issue_i,
    input  logic [3:0]      op_i,
    input  logic [AW-1:0]   rs_val_i,
    input  logic [AW-1:0]   rt_val_i,
    input  logic [OFFW-1:0] off_i,
    input  logic [JTW-1:0]  jt_i,
    output logic [AW-1:0]   pc_o,
    output logic            slot_o,
    output logic            link_we_o,
    output logic [RW-1:0]   link_idx_o,
    output logic [AW-1:0]   link_val_o
);
    typedef struct packed {
        logic [AW-1:0] pc;
        logic          pend;
        logic [AW-1:0] tgt;
    } seq_s;

    seq_s          seq_d;
    seq_s          seq_q;
    logic          take;
    logic          is_link;
    tgt_kind_e     kind;
    logic [AW-1:0] tgt;
    logic [AW-1:0] ret_addr;

    pcs_cond #(.DW(AW)) cond_i (
        .op_i   (op_i),
        .rs_i   (rs_val_i),
        .rt_i   (rt_val_i),
        .take_o (take),
        .link_o (is_link),
        .kind_o (kind)
    );

    pcs_target #(.AW(AW), .OFFW(OFFW), .JTW(JTW)) tgt_i (
        .kind_i (kind),
        .pc_i   (seq_q.pc),
        .rs_i   (rs_val_i),
        .off_i  (off_i),
        .jt_i   (jt_i),
        .tgt_o  (tgt),
        .link_o (ret_addr)
    );

    always_comb begin
        seq_d     = seq_q;
        link_we_o = 1'b0;
        if (issue_i) begin
            if (seq_q.pend) begin
                seq_d.pc   = seq_q.tgt;
                seq_d.pend = 1'b0;
            end else begin
                seq_d.pc  = seq_q.pc + AW'(4);
                link_we_o = is_link;
                if (take) begin
                    seq_d.pend = 1'b1;
                    seq_d.tgt  = tgt;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            seq_q.pc   <= AW'(RESET_PC);
            seq_q.pend <= 1'b0;
            seq_q.tgt  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pc_o       = seq_q.pc;
    assign slot_o     = seq_q.pend;
    assign link_idx_o = RW'(LINK_REG);
    assign link_val_o = ret_addr;
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk_i,
    input logic          rst_n_i,
    input logic          issue_i,
    input logic [3:0]    op_i,
    input logic [AW-1:0] pc_o,
    input logic          slot_o,
    input logic          link_we_o
);
    AST_PC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pc_o[1:0] == 2'b00); // R9

    AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !issue_i |=> $stable(pc_o) && $stable(slot_o)); // R2

    AST_STALL_NO_LINK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !issue_i |-> !link_we_o); // R2

    AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        issue_i && !slot_o && op_i == 4'd0 |=> pc_o == $past(pc_o) + AW'(4) && !slot_o); // R3

    AST_SLOT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        issue_i && !slot_o |=> pc_o == $past(pc_o) + AW'(4)); // R7

    AST_SLOT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        issue_i && slot_o |=> !slot_o); // R7

    AST_NO_LINK_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        slot_o |-> !link_we_o); // R11

    AST_LINK_ON_CALL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        issue_i && !slot_o && (op_i == 4'd7 || op_i == 4'd8 || op_i == 4'd10) |-> link_we_o); // R10
endmodule

bind pc_seq pc_seq_chk #(.AW(AW)) chk_i (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .issue_i   (issue_i),
    .op_i      (op_i),
    .pc_o      (pc_o),
    .slot_o    (slot_o),
    .link_we_o (link_we_o)
);

// File: tb/pc_seq_tb_top.sv
module pc_seq_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RST_VEC    = 32'hA000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] rs = '0;
    logic [31:0] rt = '0;
    logic [15:0] off = '0;
    logic [25:0] jt = '0;
    logic [31:0] pc;
    logic        slot;
    logic        lwe;
    logic [4:0]  lidx;
    logic [31:0] lval;

    int total = 0;
    int bad = 0;

    logic [31:0] m_pc;
    logic        m_pend;
    logic [31:0] m_tgt;
    string       m_tag;
    string       m_ptag;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_seq #(.RESET_PC(RST_VEC)) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .issue_i(issue), .op_i(op),
        .rs_val_i(rs), .rt_val_i(rt), .off_i(off), .jt_i(jt),
        .pc_o(pc), .slot_o(slot), .link_we_o(lwe),
        .link_idx_o(lidx), .link_val_o(lval)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_take(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
        case (o)
            4'd1: return a == b;                  // R4
            4'd2: return a != b;                  // R4
            4'd3: return $signed(a) <= 0;         // R5
            4'd4: return $signed(a) > 0;          // R5
            4'd5, 4'd7: return $signed(a) < 0;    // R5
            4'd6, 4'd8: return $signed(a) >= 0;   // R5
            4'd9, 4'd10, 4'd11: return 1'b1;      // R8 R9
            default: return 1'b0;                 // R3
        endcase
    endfunction

    function automatic logic [31:0] exp_tgt(input logic [3:0] o, input logic [31:0] p,
                                           input logic [31:0] a, input logic [15:0] d,
                                           input logic [25:0] j);
        logic [31:0] nxt = p + 32'd4;
        if (o == 4'd9 || o == 4'd10) return {nxt[31:28], j, 2'b00};   // R8
        if (o == 4'd11) return a & 32'hFFFF_FFFC;                     // R9
        return nxt + ($signed({{16{d[15]}}, d}) * 4);                 // R6
    endfunction

    function automatic string op_tag(input logic [3:0] o);
        if (o == 4'd9 || o == 4'd10) return "R8";
        if (o == 4'd11) return "R9";
        return "R6";
    endfunction

    task automatic step(input logic i, input logic [3:0] o, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] d, input logic [25:0] j);
        bit lw;
        @(negedge clk);
        check(pc == m_pc, {m_tag, " pc"}, pc, m_pc);
        check(slot == m_pend, "R7 slot flag", {31'd0, slot}, {31'd0, m_pend});
        issue = i; op = o; rs = a; rt = b; off = d; jt = j;
        #1;
        lw = i && !m_pend && (o == 4'd7 || o == 4'd8 || o == 4'd10);
        check(lwe == lw, m_pend ? "R11 link enable" : (i ? "R10 link enable" : "R2 link enable"),
              {31'd0, lwe}, {31'd0, lw});
        if (lw) begin
            check(lidx == 5'd31, "R10 link index", {27'd0, lidx}, 32'd31);
            check(lval == m_pc + 32'd8, "R10 link value", lval, m_pc + 32'd8);
        end
        if (!i) begin
            m_tag = "R2";
        end else if (m_pend) begin
            m_pc   = m_tgt;
            m_pend = 1'b0;
            m_tag  = (o >= 4'd1 && o <= 4'd11) ? {m_ptag, " R11"} : {m_ptag, " R7"};
        end else begin
            if (exp_take(o, a, b)) begin
                m_tgt  = exp_tgt(o, m_pc, a, d, j);
                m_pend = 1'b1;
                m_ptag = op_tag(o);
                m_tag  = "R7";
            end else begin
                m_tag = (o >= 4'd1 && o <= 4'd8) ? "R4 R5 not-taken" : "R3";
            end
            m_pc = m_pc + 32'd4;
        end
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom % 7)
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_pc = RST_VEC; m_pend = 1'b0; m_tgt = '0; m_tag = "R1"; m_ptag = "R6";
        repeat (3) @(negedge clk);
        check(pc == RST_VEC, "R1 reset pc", pc, RST_VEC);
        check(slot == 1'b0, "R1 reset slot", {31'd0, slot}, 32'd0);
        check(lwe == 1'b0, "R1 reset link", {31'd0, lwe}, 32'd0);
        rst_n = 1'b1;
        // directed corner cases
        step(1, 4'd0,  0, 0, 0, 0);                          // R3 plain
        step(1, 4'd1,  5, 5, 16'h0010, 0);                   // R4 BEQ taken
        step(0, 4'd0,  0, 0, 0, 0);                          // R2 stall in slot
        step(1, 4'd10, 0, 0, 0, 26'h123);                    // R11 call in slot ignored
        step(1, 4'd2,  7, 7, 16'hFFF0, 0);                   // R4 BNE not taken
        step(1, 4'd3,  0, 0, 16'hFFFE, 0);                   // R5 BLEZ zero, backward
        step(1, 4'd0,  0, 0, 0, 0);
        step(1, 4'd4,  0, 0, 16'h0004, 0);                   // R5 BGTZ zero not taken
        step(1, 4'd7,  1, 0, 16'h0004, 0);                   // R10 link not taken
        step(1, 4'd8,  0, 0, 16'h0008, 0);                   // R10 link taken at zero
        step(1, 4'd0,  0, 0, 0, 0);
        step(1, 4'd9,  0, 0, 0, 26'h3FF_FFFF);               // R8 region kept
        step(1, 4'd5,  32'h8000_0000, 0, 0, 0);               // slot
        step(1, 4'd11, 32'h0000_1237, 0, 0, 0);               // R9 low bits cleared
        step(1, 4'd0,  0, 0, 0, 0);
        step(1, 4'd15, 0, 0, 0, 0);                          // R3 unused code
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] a = pick_val();
            logic [31:0] b = ($urandom % 3 == 0) ? a : pick_val();
            step(($urandom % 8) != 0, 4'($urandom % 16), a, b, 16'($urandom), 26'($urandom));
        end
        step(0, 4'd0, 0, 0, 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule